// File: doc/BRIEF.md
# Bank-Swizzle Address Remapper

This block turns a logical position inside a tile into a physical byte address in a banked scratchpad. The logical position is an atom index (group), a row inside the atom and a byte column inside the row. A tile writer or reader puts it in front of the scratchpad. An atom is eight rows tall and as wide as the chosen swizzle span. Inside an atom the remapper permutes 16-byte chunks by row, so the eight rows of one logical column fall into different banks. The permutation changes only where a byte is placed. Which logical element the byte belongs to never changes.

Four modes are offered, with codes 0 to 3: no swizzle, a 32-byte span, a 64-byte span and a 128-byte span. A mode with a span is legal only when the tile's contiguous dimension, given in bytes on `tileBytes`, is at least as large as the span. For an illegal mode the block raises `errFlag` and places the chunks unpermuted. In the same cycle it reports the widest legal mode for the tile, so a caller can pick a mode from that output. A second input carries a physical address. The block maps it back to the logical position under the same mode and base, so a reader recovers what the writer stored.

The block has a single register stage. A request that is valid on one rising edge produces its results on the next edge.

Top module: `swz_remap`

## Requirements
- R1: While reset (`rstN` low) is applied, and after it, until the first request, `outValid`, `physAddr` and `errFlag` are 0.
- R2: `outValid` is 1 exactly in the cycle that follows a cycle in which `reqValid` was 1, and results appear in that cycle.
- R3: Mode code 0 (no swizzle) uses a row pitch of 128 bytes and an atom size of 1024 bytes. The address is base + group*1024 + row*128 + col, with no permutation.
- R4: Mode code 1 (32-byte span) uses a pitch of 32 bytes and an atom size of 256 bytes. The chunk index col[6:4] is XORed with row&1.
- R5: Mode code 2 (64-byte span) uses a pitch of 64 bytes and an atom size of 512 bytes. The chunk index is XORed with row&3.
- R6: Mode code 3 (128-byte span) uses a pitch of 128 bytes and an atom size of 1024 bytes. The chunk index is XORed with row&7, so the eight rows of one column land in eight different chunk slots.
- R7: Column bits at or above the span width of the mode are ignored, so the column is taken modulo the span (128 for code 0).
- R8: A nonzero mode whose span exceeds `tileBytes` sets `errFlag` to 1. The address then keeps that mode's pitch and atom size but applies no XOR. A legal mode gives `errFlag` 0.
- R9: `bestMode` gives the code of the widest legal mode: 3 when tileBytes >= 128, 2 when it is >= 64, 1 when it is >= 32, otherwise 0.
- R10: When `invAddr` carries an address that the forward map produced, with the same mode, base and tileBytes, the outputs `invGroup`, `invRow` and `invCol` return the original group and row and the column modulo the span.
- R11: In every mode the low four bits of (physAddr - base) equal col[3:0], so the byte offset within a chunk is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request strobe; inputs are sampled on this edge |
| mode | input | 2 | Swizzle mode code 0..3 |
| tileBytes | input | TILE_W | Contiguous tile dimension in bytes |
| base | input | ADDR_W | Tile base byte address |
| group | input | GROUP_W | Atom index |
| row | input | 3 | Row inside the atom |
| col | input | 7 | Byte column inside the row |
| invAddr | input | ADDR_W | Physical address for the inverse map |
| outValid | output | 1 | Results valid |
| physAddr | output | ADDR_W | Physical byte address |
| errFlag | output | 1 | Mode too wide for the tile |
| bestMode | output | 2 | Widest legal mode for tileBytes |
| invGroup | output | GROUP_W | Recovered atom index |
| invRow | output | 3 | Recovered row |
| invCol | output | 7 | Recovered column |

## Verification
The bench builds the block with its default parameters: a 20-bit address, a 6-bit group and a 10-bit tile width. With these values a group of 3 at the 1024-byte atom size is in range, and tileBytes can go above 128, so the 128-byte mode is legal in some cases and too wide in others. Nonzero bases show that the base is added and that the inverse map subtracts it. Tile widths just below and at each span exercise every boundary of the legality rule and of the widest-mode selection.

// File: rtl/swz_pkg.sv
package swz_pkg;
  // fixed geometry: 16-byte chunks, 8 rows per atom, up to 8 chunks per row
  localparam int CHUNK_LOG = 4;
  localparam int ROW_W     = 3;
  localparam int COL_W     = CHUNK_LOG + ROW_W;

  typedef enum logic [1:0] {
    SWZ_NONE = 2'd0,
    SWZ_32   = 2'd1,
    SWZ_64   = 2'd2,
    SWZ_128  = 2'd3
  } swzMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       xorEn;
    logic [2:0] rowMask;
    logic [2:0] pitchLog;
  } swzStrobe_t;
endpackage

// File: rtl/swz_ctrl.sv
module swz_ctrl
  import swz_pkg::*;
#(
  parameter int TILE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        mode,
  input  logic [TILE_W-1:0] tileBytes,
  output swzStrobe_t        strobe,
  output logic              outValid,
  output logic              errFlag,
  output logic [1:0]        bestMode
);
  swzMode_e   modeE;
  logic [2:0] pitchLog;
  logic [2:0] rowMaskM;
  logic       illegal;
  logic [1:0] bestNext;
  logic [31:0] tileExt;
  logic [31:0] spanBytes;

  assign modeE   = swzMode_e'(mode);
  assign tileExt = 32'(tileBytes);

  always_comb begin
    case (modeE)
      SWZ_32:  begin pitchLog = 3'd5; rowMaskM = 3'd1; end
      SWZ_64:  begin pitchLog = 3'd6; rowMaskM = 3'd3; end
      SWZ_128: begin pitchLog = 3'd7; rowMaskM = 3'd7; end
      default: begin pitchLog = 3'd7; rowMaskM = 3'd0; end
    endcase
  end

  assign spanBytes = 32'd1 << pitchLog;
  assign illegal   = (modeE != SWZ_NONE) && (tileExt < spanBytes);

  always_comb begin
    if (tileExt >= 32'd128)     bestNext = 2'd3;
    else if (tileExt >= 32'd64) bestNext = 2'd2;
    else if (tileExt >= 32'd32) bestNext = 2'd1;
    else                        bestNext = 2'd0;
  end

  always_comb begin
    strobe.load     = reqValid;
    strobe.xorEn    = !illegal && (modeE != SWZ_NONE);
    strobe.rowMask  = rowMaskM;
    strobe.pitchLog = pitchLog;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      errFlag  <= 1'b0;
      bestMode <= 2'd0;
    end else begin
      outValid <= reqValid;
      if (reqValid) begin
        errFlag  <= illegal;
        bestMode <= bestNext;
      end
    end
  end
endmodule

// File: rtl/swz_path.sv
module swz_path
  import swz_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int GROUP_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  swzStrobe_t         strobe,
  input  logic [ADDR_W-1:0]  base,
  input  logic [GROUP_W-1:0] group,
  input  logic [ROW_W-1:0]   row,
  input  logic [COL_W-1:0]   col,
  input  logic [ADDR_W-1:0]  invAddr,
  output logic [ADDR_W-1:0]  physAddr,
  output logic [GROUP_W-1:0] invGroup,
  output logic [ROW_W-1:0]   invRow,
  output logic [COL_W-1:0]   invCol
);
  logic [3:0]         atomLog;
  logic [COL_W:0]     spanFull;
  logic [COL_W-1:0]   colMask;
  logic [COL_W-1:0]   colM;
  logic [ROW_W-1:0]   fwdKey;
  logic [ROW_W-1:0]   physChunk;
  logic [ADDR_W-1:0]  fwdOff;
  logic [ADDR_W-1:0]  fwdAddr;
  logic [ADDR_W-1:0]  invOff;
  logic [ROW_W-1:0]   iRow;
  logic [GROUP_W-1:0] iGroup;
  logic [ROW_W-1:0]   iKey;
  logic [ROW_W-1:0]   iChunk;
  logic [COL_W-1:0]   iCol;

  assign atomLog  = {1'b0, strobe.pitchLog} + 4'd3;
  assign spanFull = (COL_W+1)'(1) << strobe.pitchLog;
  assign colMask  = COL_W'(spanFull - 1'b1);

  // forward map
  assign colM      = col & colMask;
  assign fwdKey    = strobe.xorEn ? (row & strobe.rowMask) : '0;
  assign physChunk = colM[COL_W-1:CHUNK_LOG] ^ fwdKey;
  assign fwdOff    = (ADDR_W'(group) << atomLog)
                   + (ADDR_W'(row) << strobe.pitchLog)
                   + ADDR_W'({physChunk, colM[CHUNK_LOG-1:0]});
  assign fwdAddr   = base + fwdOff;

  // inverse map
  assign invOff = invAddr - base;
  assign iRow   = ROW_W'(invOff >> strobe.pitchLog);
  assign iGroup = GROUP_W'(invOff >> atomLog);
  assign iKey   = strobe.xorEn ? (iRow & strobe.rowMask) : '0;
  assign iChunk = (invOff[COL_W-1:CHUNK_LOG] & colMask[COL_W-1:CHUNK_LOG]) ^ iKey;
  assign iCol   = {iChunk, invOff[CHUNK_LOG-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      physAddr <= '0;
      invGroup <= '0;
      invRow   <= '0;
      invCol   <= '0;
    end else if (strobe.load) begin
      physAddr <= fwdAddr;
      invGroup <= iGroup;
      invRow   <= iRow;
      invCol   <= iCol;
    end
  end
endmodule

// File: rtl/swz_remap.sv
module swz_remap
  import swz_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int GROUP_W = 6,
  parameter int TILE_W  = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         mode,
  input  logic [TILE_W-1:0]  tileBytes,
  input  logic [ADDR_W-1:0]  base,
  input  logic [GROUP_W-1:0] group,
  input  logic [2:0]         row,
  input  logic [6:0]         col,
  input  logic [ADDR_W-1:0]  invAddr,
  output logic               outValid,
  output logic [ADDR_W-1:0]  physAddr,
  output logic               errFlag,
  output logic [1:0]         bestMode,
  output logic [GROUP_W-1:0] invGroup,
  output logic [2:0]         invRow,
  output logic [6:0]         invCol
);
  swzStrobe_t strobe;

  swz_ctrl #(.TILE_W(TILE_W)) ctrlI (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode),
    .tileBytes(tileBytes), .strobe(strobe), .outValid(outValid),
    .errFlag(errFlag), .bestMode(bestMode)
  );

  swz_path #(.ADDR_W(ADDR_W), .GROUP_W(GROUP_W)) pathI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .base(base), .group(group),
    .row(row), .col(col), .invAddr(invAddr), .physAddr(physAddr),
    .invGroup(invGroup), .invRow(invRow), .invCol(invCol)
  );
endmodule

// File: rtl/swz_remap_chk.sv
module swz_remap_chk #(
  parameter int ADDR_W = 20,
  parameter int TILE_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        mode,
  input logic [TILE_W-1:0] tileBytes,
  input logic [ADDR_W-1:0] base,
  input logic [6:0]        col,
  input logic              outValid,
  input logic [ADDR_W-1:0] physAddr,
  input logic              errFlag,
  input logic [1:0]        bestMode
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> (!outValid && !errFlag && physAddr == '0));
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN) reqValid |=> outValid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN) !reqValid |=> !outValid);
  // R8
  too_wide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode != 2'd0 && (32'(tileBytes) < (32'd16 << mode))) |=> errFlag);
  // R8
  plain_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 2'd0) |=> !errFlag);
  // R9
  best_wide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && 32'(tileBytes) >= 32'd128) |=> bestMode == 2'd3);
  // R9
  best_narrow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && 32'(tileBytes) < 32'd32) |=> bestMode == 2'd0);
  // R11
  byte_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (4'(physAddr - $past(base)) == $past(col[3:0])));
endmodule

bind swz_remap swz_remap_chk #(.ADDR_W(ADDR_W), .TILE_W(TILE_W)) chkI (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode),
  .tileBytes(tileBytes), .base(base), .col(col), .outValid(outValid),
  .physAddr(physAddr), .errFlag(errFlag), .bestMode(bestMode)
);

// File: tb/swz_remap_test.sv
`timescale 1ns/1ps
module swz_remap_test;
  localparam int ADDR_W = 20;
  localparam int GROUP_W = 6;
  localparam int TILE_W = 10;

  typedef struct packed {
    logic [1:0]  md;
    logic [9:0]  tile;
    logic [5:0]  grp;
    logic [2:0]  rw;
    logic [6:0]  cl;
    logic [19:0] bs;
    logic [19:0] expAddr;
    logic        expErr;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 10'd64,  6'd1, 3'd0 + 3'd2, 7'h05, 20'h100, 20'h605, 1'b0},
    '{2'd1, 10'd32,  6'd2, 3'd3, 7'h15, 20'h100, 20'h365, 1'b0},
    '{2'd2, 10'd64,  6'd1, 3'd6, 7'h27, 20'h100, 20'h487, 1'b0},
    '{2'd3, 10'd128, 6'd3, 3'd5, 7'h1A, 20'h100, 20'hFCA, 1'b0},
    '{2'd1, 10'd32,  6'd0, 3'd1, 7'h47, 20'h100, 20'h137, 1'b0},
    '{2'd3, 10'd64,  6'd1, 3'd5, 7'h1A, 20'h100, 20'h79A, 1'b1},
    '{2'd2, 10'd32,  6'd0, 3'd3, 7'h31, 20'h100, 20'h1F1, 1'b1},
    '{2'd3, 10'd200, 6'd0, 3'd7, 7'h7F, 20'h000, 20'h38F, 1'b0}
  };
  localparam string VTAG [8] = '{"R3", "R4", "R5", "R6", "R7", "R8", "R8", "R6"};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] mode = '0;
  logic [TILE_W-1:0] tileBytes = '0;
  logic [ADDR_W-1:0] base = '0;
  logic [GROUP_W-1:0] group = '0;
  logic [2:0] row = '0;
  logic [6:0] col = '0;
  logic [ADDR_W-1:0] invAddr = '0;
  logic outValid, errFlag;
  logic [ADDR_W-1:0] physAddr;
  logic [1:0] bestMode;
  logic [GROUP_W-1:0] invGroup;
  logic [2:0] invRow;
  logic [6:0] invCol;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  swz_remap #(.ADDR_W(ADDR_W), .GROUP_W(GROUP_W), .TILE_W(TILE_W)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode),
    .tileBytes(tileBytes), .base(base), .group(group), .row(row), .col(col),
    .invAddr(invAddr), .outValid(outValid), .physAddr(physAddr),
    .errFlag(errFlag), .bestMode(bestMode), .invGroup(invGroup),
    .invRow(invRow), .invCol(invCol)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; results are sampled at the next falling edge
  task automatic request(input logic [1:0] m, input logic [9:0] t, input logic [19:0] b,
                         input logic [5:0] g, input logic [2:0] r, input logic [6:0] c,
                         input logic [19:0] ia);
    mode = m; tileBytes = t; base = b; group = g; row = r; col = c; invAddr = ia;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] fwd;
    logic [6:0] spanMask;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 valid in reset", 32'(outValid), 0);
    check("R1 addr in reset", 32'(physAddr), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 err after reset", 32'(errFlag), 0);
    check("R1 valid after reset", 32'(outValid), 0);

    // table walk: R3..R8
    for (int i = 0; i < 8; i++) begin
      request(VECS[i].md, VECS[i].tile, VECS[i].bs, VECS[i].grp, VECS[i].rw, VECS[i].cl, '0);
      check({VTAG[i], " addr"}, 32'(physAddr), 32'(VECS[i].expAddr));
      check("R8 err flag", 32'(errFlag), 32'(VECS[i].expErr));
      check("R2 valid after request", 32'(outValid), 1);
    end
    @(negedge clk);
    check("R2 valid drops", 32'(outValid), 0);

    // R9 widest legal mode at each boundary
    begin
      logic [9:0] tiles [8] = '{10'd10, 10'd31, 10'd32, 10'd63, 10'd64, 10'd127, 10'd128, 10'd500};
      logic [1:0] bests [8] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd3};
      for (int i = 0; i < 8; i++) begin
        request(2'd0, tiles[i], '0, '0, '0, '0, '0);
        check("R9 best mode", 32'(bestMode), 32'(bests[i]));
      end
    end

    // R6 column spread over chunk slots in the 128-byte mode
    for (int r = 0; r < 8; r++) begin
      request(2'd3, 10'd128, 20'h0, 6'd0, 3'(r), 7'h05, '0);
      check("R6 chunk slot", 32'(physAddr[6:4]), 32'(r));
    end

    // R10 round trip in every mode
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 3; k++) begin
        logic [5:0] g;
        logic [2:0] r;
        logic [6:0] c;
        g = 6'(k + 1);
        r = 3'((k * 3 + m) & 7);
        c = 7'((k * 37 + m * 11) & 127);
        spanMask = (m == 0) ? 7'h7F : 7'((16 << m) - 1);
        request(2'(m), 10'd128, 20'h2340, g, r, c, '0);
        fwd = physAddr;
        request(2'(m), 10'd128, 20'h2340, '0, '0, '0, fwd);
        check("R10 group", 32'(invGroup), 32'(g));
        check("R10 row", 32'(invRow), 32'(r));
        check("R10 col", 32'(invCol), 32'(c & spanMask));
      end
    end

    // R11 byte offset kept with an unaligned base
    request(2'd2, 10'd64, 20'h0107, 6'd2, 3'd3, 7'h2B, '0);
    check("R11 byte offset", 32'(4'(physAddr - 20'h0107)), 32'hB);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule